// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block gathers 32 level-sensitive interrupt lines for a primary interrupt controller. Each clock it captures the input levels into a raw level register. It ANDs that register with a software-controlled enable mask and reduces the result to one combined request. The request is presented on upstream line 31.

A subset of lines, 21 through 30, can also be routed straight to the matching upstream lines, bypassing the mask. Software selects which of those lines are routed this way through a per-line routing enable.

Software reaches the block over a simple 32-bit register bus with 10-bit word addressing. The address space covers a 4 KiB window. Masks are changed only through set/clear register pairs, so no read-modify-write sequence is ever needed.

Top module: `sec_irq_ctrl`

## Requirements
- R1: The raw level register captures `irq_in` on every clock edge, and reading word 1 returns it.
- R2: `irq_out[31]` is high exactly when the raw level register ANDed with the enable mask is non-zero. It changes on the clock edge that captures the causing input change or register write.
- R3: Reading word 0 returns the raw level register ANDed with the enable mask.
- R4: Writing word 2 ORs the written value into the enable mask. Writing word 3 clears every mask bit that is 1 in the value. Reading word 2 returns the mask.
- R5: Writing a non-zero value to word 4 sets enable bit 0, and writing a non-zero value to word 5 clears it. Writing zero to either word leaves the mask unchanged.
- R6: Reading word 4 returns bit 0 of the raw level register in bit 0, and zero in every other bit.
- R7: Writing word 8 ORs in only bits 21..30 of the written value (value AND 0x7FE00000) into the routing enable. Writing word 9 clears the routing bits that are set in the value. Reading word 8 returns the routing enable, which never has a bit set outside 21..30.
- R8: For each i in 21..30, `irq_out[i]` equals raw level bit i when routing bit i is set, and is low otherwise. `irq_out[20:0]` is always low.
- R9: Reading any word other than 0, 1, 2, 4 or 8 returns zero. Writing any word other than 2, 3, 4, 5, 8 or 9 changes no state. `bus_rdata` is zero whenever no read is selected.
- R10: A synchronous active-low reset clears the raw level register, the enable mask, the routing enable and every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the select |
| irq_out | output | 32 | Upstream lines: 31 combined, 21..30 routed, 0..20 low |

## Verification
A wrong enable-mask bit shows on `irq_out[31]` one clock after the matching input is raised. It shows at once in a read of word 0 or word 2. A corrupt routing bit changes the matching upstream line in the cycle after its input moves. A stray bit outside 21..30 is caught by the next read of word 8. A write that leaks from an unmapped or zero-valued access shows up on the next read of the mask registers or on the combined line one clock later.

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int N     = 32,
  parameter int AW    = 10,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30,
  parameter int COMB  = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  output logic [N-1:0]  irq_out
);
  localparam logic [N-1:0] PT_MASK = ({N{1'b1}} >> (N-1-PT_HI)) & ({N{1'b1}} << PT_LO);
  localparam logic [AW-1:0] W_STAT  = AW'(0);
  localparam logic [AW-1:0] W_RAW   = AW'(1);
  localparam logic [AW-1:0] W_ENSET = AW'(2);
  localparam logic [AW-1:0] W_ENCLR = AW'(3);
  localparam logic [AW-1:0] W_SWSET = AW'(4);
  localparam logic [AW-1:0] W_SWCLR = AW'(5);
  localparam logic [AW-1:0] W_PTSET = AW'(8);
  localparam logic [AW-1:0] W_PTCLR = AW'(9);

  logic [N-1:0] lvl_q, mask_q, pt_q, mask_d, pt_d;
  logic         comb_q;
  logic         wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_comb begin
    mask_d = mask_q;
    pt_d   = pt_q;
    if (wr_en) begin
      case (bus_addr)
        W_ENSET: mask_d = mask_q | bus_wdata;
        W_ENCLR: mask_d = mask_q & ~bus_wdata;
        W_SWSET: if (|bus_wdata) mask_d[0] = 1'b1;
        W_SWCLR: if (|bus_wdata) mask_d[0] = 1'b0;
        W_PTSET: pt_d = pt_q | (bus_wdata & PT_MASK);
        W_PTCLR: pt_d = pt_q & ~bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      mask_q <= '0;
      pt_q   <= '0;
      comb_q <= 1'b0;
    end else begin
      lvl_q  <= irq_in;
      mask_q <= mask_d;
      pt_q   <= pt_d;
      comb_q <= |(irq_in & mask_d);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        W_STAT:  bus_rdata = lvl_q & mask_q;
        W_RAW:   bus_rdata = lvl_q;
        W_ENSET: bus_rdata = mask_q;
        W_SWSET: bus_rdata = {{(N-1){1'b0}}, lvl_q[0]};
        W_PTSET: bus_rdata = pt_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    if (i == COMB) begin : g_comb
      assign irq_out[i] = comb_q;
    end else if (i >= PT_LO && i <= PT_HI) begin : g_route
      assign irq_out[i] = lvl_q[i] & pt_q[i];
    end else begin : g_tie
      assign irq_out[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sec_irq_chk.sv
module sec_irq_chk #(
  parameter int N     = 32,
  parameter int AW    = 10,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30,
  parameter int COMB  = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  irq_in,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  bus_rdata,
  input logic [N-1:0]  irq_out,
  input logic [N-1:0]  lvl_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  pt_q
);
  localparam logic [N-1:0] PT_MASK = ({N{1'b1}} >> (N-1-PT_HI)) & ({N{1'b1}} << PT_LO);
  localparam logic [N-1:0] LOW_MASK = ~({N{1'b1}} << PT_LO);

  a_r1_level_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> lvl_q == $past(irq_in));

  a_r2_combined: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[COMB] == |(lvl_q & mask_q));

  a_r4_enset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(2)) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  a_r5_zero_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr == AW'(4) || bus_addr == AW'(5)) && bus_wdata == '0) |=> $stable(mask_q));

  a_r7_route_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_q & ~PT_MASK) == '0);

  a_r8_low_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & LOW_MASK) == '0);

  a_r9_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);

  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !(bus_addr inside {AW'(2), AW'(3), AW'(4), AW'(5), AW'(8), AW'(9)}))
    |=> ($stable(mask_q) && $stable(pt_q)));
endmodule

bind sec_irq_ctrl sec_irq_chk #(.N(N), .AW(AW), .PT_LO(PT_LO), .PT_HI(PT_HI), .COMB(COMB)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .lvl_q(lvl_q), .mask_q(mask_q), .pt_q(pt_q)
);

// File: tb/sim_sec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sec_irq_ctrl;
  localparam logic [31:0] PTM = 32'h7FE0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, irq_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_lvl = '0, m_mask = '0, m_pt = '0;

  always #4 clk = ~clk;

  sec_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    case (a)
      10'd0: return m_lvl & m_mask;
      10'd1: return m_lvl;
      10'd2: return m_mask;
      10'd4: return {31'b0, m_lvl[0]};
      10'd8: return m_pt;
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] exp_out();
    logic [31:0] o;
    o = m_lvl & m_pt & PTM;
    o[31] = |(m_lvl & m_mask);
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic step(input logic [31:0] irq, input logic sel, input logic wr,
                      input logic [9:0] a, input logic [31:0] wd, input string req);
    irq_in = irq; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #1;
    if (sel && !wr) check({req, " read"}, bus_rdata, exp_read(a));
    else if (!sel) check("R9 idle rdata", bus_rdata, '0);
    @(posedge clk);
    m_lvl = irq;
    if (sel && wr) begin
      case (a)
        10'd2: m_mask = m_mask | wd;
        10'd3: m_mask = m_mask & ~wd;
        10'd4: if (wd != 0) m_mask[0] = 1'b1;
        10'd5: if (wd != 0) m_mask[0] = 1'b0;
        10'd8: m_pt = m_pt | (wd & PTM);
        10'd9: m_pt = m_pt & ~wd;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_sel = 1'b0;
    check({req, " R2 R8 irq_out"}, irq_out, exp_out());
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0;
    for (int w = 0; w < 10; w++) begin
      bus_addr = 10'(w); #1;
      check("R10 reset read", bus_rdata, '0);
      @(negedge clk);
    end
    check("R10 reset irq_out", irq_out, '0);
    bus_sel = 1'b0; irq_in = '0;
    @(negedge clk); rst_n = 1'b1;

    // directed
    step(32'h0000_0001, 0, 0, 0, 0, "R1 idle");
    step(32'h0000_0001, 1, 0, 10'd1, 0, "R1 raw");
    step(32'h0000_0001, 1, 0, 10'd4, 0, "R6 softint");
    step(32'h0000_0001, 1, 1, 10'd4, 32'h0, "R5 zero set");
    step(32'h0000_0001, 1, 0, 10'd2, 0, "R5 mask after zero set");
    step(32'h0000_0001, 1, 1, 10'd4, 32'h100, "R5 nonzero set");
    step(32'h0000_0001, 1, 0, 10'd0, 0, "R3 status");
    step(32'h0000_0001, 1, 1, 10'd5, 32'h0, "R5 zero clear");
    step(32'h0000_0001, 1, 0, 10'd2, 0, "R5 mask after zero clear");
    step(32'h0000_0001, 1, 1, 10'd5, 32'h8000_0000, "R5 nonzero clear");
    step(32'h0000_0001, 1, 0, 10'd2, 0, "R5 mask cleared");
    step(32'h0F00_0000, 1, 1, 10'd2, 32'hFFFF_FFFF, "R4 enset all");
    step(32'h0F00_0000, 1, 1, 10'd3, 32'h0F00_0000, "R4 enclr");
    step(32'h0F00_0000, 1, 0, 10'd2, 0, "R4 mask read");
    step(32'hFFFF_FFFF, 1, 1, 10'd8, 32'hFFFF_FFFF, "R7 ptset wide");
    step(32'hFFFF_FFFF, 1, 0, 10'd8, 0, "R7 pt read");
    step(32'h5555_5555, 1, 1, 10'd9, 32'h2AA0_0000, "R7 ptclr");
    step(32'hAAAA_AAAA, 1, 1, 10'd6, 32'hFFFF_FFFF, "R9 unmapped write");
    step(32'hAAAA_AAAA, 1, 0, 10'd2, 0, "R9 mask unchanged");
    step(32'hAAAA_AAAA, 1, 0, 10'd8, 0, "R9 pt unchanged");
    step(32'hAAAA_AAAA, 1, 0, 10'd3, 0, "R9 read word3");
    step(32'hAAAA_AAAA, 1, 0, 10'd1023, 0, "R9 read top word");
    step(32'h0, 1, 1, 10'd3, 32'hFFFF_FFFF, "R4 clear all");
    step(32'h0, 1, 0, 10'd0, 0, "R3 status zero");

    // random
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r, wd;
      logic [9:0] a;
      logic sel, wr;
      r   = $urandom;
      wd  = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      a   = ($urandom_range(0, 7) == 0) ? 10'($urandom) : 10'($urandom_range(0, 9));
      sel = ($urandom_range(0, 3) != 0);
      wr  = $urandom_range(0, 1) == 1;
      step(r, sel, wr, a, wd, "R1 R3 R4 R5 R6 R7 R9 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule